// File: doc/BRIEF.md
# Multiplexed Pixel Port Serializer

This block sits between a frame buffer and a colour pipeline that consumes one pixel per pixel-clock cycle. The frame buffer delivers several pixels side by side in one wide word at a reduced rate. The block divides the pixel clock to make a load strobe, `load_out`. That strobe goes back to the frame buffer and returns to the block as the latch strobe `load_in`, either tied straight across or after a delay. Each latched word is then played out one lane per cycle, starting with lane A.

Three multiplexing ratios are available: two, four or eight pixels per load. At two and four pixels per load each lane is a 24-bit true-colour pixel. Choosing eight pixels per load narrows every lane to an 8-bit pseudo-colour index, whatever format would otherwise apply. A second divided clock, `prg_clk`, gives the pixel clock divided by 4, 8, 16 or 32 for use elsewhere in the system. Both selections sit in a small configuration register that is written through `cfg_we`. A synchronous reset sets the configuration to its defaults and points the serializer back at lane A.

Top module: `pxser_top`

## Requirements
- R1: While `rst` is high at a rising edge, the configuration returns to four pixels per load and divide-by-32. After that edge `load_out` is 1, `prg_clk` is 0 and `pseudo_mode` is 0.
- R2: `load_out` is high for exactly one cycle in every N cycles, where N is the current pixels-per-load ratio. After reset its first high cycle is the one that follows the reset edge.
- R3: `prg_clk` is bit k of a 5-bit free-running counter that is cleared by reset, with k = `cfg_pdiv`+1. The codes are 0 for /4, 1 for /8, 2 for /16 and 3 for /32. The result is a square wave of period 4, 8, 16 or 32 cycles.
- R4: With `cfg_mux` code 2 or 3 (eight per load), `pix_out` carries the 8-bit lane taken from bits [8i+7:8i] of the word, with bits [23:8] held at zero.
- R5: At a rising edge with `load_in` high, `pix_word` is captured. The word captured at the previous `load_in` edge moves to the output stage and lane A is shown. A word therefore starts to appear one load later.
- R6: After each load the lanes are shown in ascending order, one per cycle (A, B, C, ...). Lane i of a 24-bit format is bits [24i+23:24i]. Without a new load the lane index wraps from N-1 back to A.
- R7: A rising edge with `cfg_we` high loads `cfg_mux` and `cfg_pdiv`. The mux codes are 0 for 2:1, 1 for 4:1, and 2 or 3 for 8:1. `pseudo_mode` is 1 exactly when eight per load is selected.
- R8: A synchronous reset in mid-stream sets the lane index to A without clearing the output word, so `pix_out` shows lane A of the word already being played out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mux | input | 2 | Pixels-per-load code |
| cfg_pdiv | input | 2 | Divider code for `prg_clk` |
| load_in | input | 1 | Latch strobe returned from the frame buffer |
| pix_word | input | 96 | Multiplexed pixel word |
| load_out | output | 1 | Divided load strobe |
| prg_clk | output | 1 | Programmable divided clock |
| pix_out | output | 24 | Serialized pixel |
| pseudo_mode | output | 1 | High when lanes are 8-bit indices |

## Verification
The bench drives `load_in` three ways: looped straight back from `load_out`, delayed by one cycle, and held low. If the design tied lane A to the `load_out` phase rather than to the latch, the delayed runs would show lanes out of order. If it failed to wrap, the lanes would run off the end of the word. The bench switches the ratio in mid-stream, including the spare 8:1 code. A design that decoded only one of the two 8:1 codes, or that left the upper bits set in pseudo-colour mode, would give a wrong `pix_out`. The bench also applies a reset while a word is being played out and expects lane A of that same word. A design that cleared the data, or that left the lane index where it was, would show zeros or a later lane.

// File: rtl/pxser_pkg.sv
package pxser_pkg;

    localparam int MAX_RATIO = 8;
    localparam int PTR_W     = 3;
    localparam int PDIV_W    = 5;

    typedef enum logic [1:0] {
        MUX_2TO1  = 2'd0,
        MUX_4TO1  = 2'd1,
        MUX_8TO1  = 2'd2,
        MUX_8TO1B = 2'd3
    } mux_e;

    typedef enum logic [1:0] {
        PDIV_4  = 2'd0,
        PDIV_8  = 2'd1,
        PDIV_16 = 2'd2,
        PDIV_32 = 2'd3
    } pdiv_e;

    typedef struct packed {
        mux_e  mux;
        pdiv_e pdiv;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '{mux: MUX_4TO1, pdiv: PDIV_32};

    function automatic logic [3:0] mux_ratio(input mux_e m);
        case (m)
            MUX_2TO1: return 4'd2;
            MUX_4TO1: return 4'd4;
            default:  return 4'd8;
        endcase
    endfunction

    function automatic logic mux_is_pseudo(input mux_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/pxser_load_timer.sv
module pxser_load_timer
    import pxser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ratio,
    output logic       load_out
);
    logic [PTR_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if ({1'b0, phase_q} >= ratio - 4'd1)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign load_out = (phase_q == '0);

    // R2: the strobe never stays high two cycles running
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        load_out |=> !load_out);

endmodule

// File: rtl/pxser_prog_div.sv
module pxser_prog_div
    import pxser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pdiv_e pdiv,
    output logic  prg_clk
);
    logic [PDIV_W-1:0] cnt_q;
    logic [2:0]        tap;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign tap     = {1'b0, pdiv} + 3'd1;
    assign prg_clk = cnt_q[tap];

    // R3: a high phase lasts at least two cycles while the divider is unchanged
    p_min_high_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(prg_clk) && $stable(pdiv)) |=> (prg_clk || !$stable(pdiv)));

endmodule

// File: rtl/pxser_lane_mux.sv
module pxser_lane_mux
    import pxser_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CW    = 24,
    parameter int PW    = 8
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            load_in,
    input  logic [LANES*CW-1:0] word_in,
    input  logic [3:0]      ratio,
    input  logic            pseudo,
    output logic [CW-1:0]   pix_out
);
    localparam int WW   = LANES * CW;
    localparam int WSEL = $clog2(LANES);

    logic [WW-1:0]    hold_q;
    logic [WW-1:0]    shown_q;
    logic [PTR_W-1:0] ptr_q;
    logic [CW-1:0]    wide_lane [LANES];
    logic [PW-1:0]    narrow_lane [MAX_RATIO];

    // data stage carries no reset so a mid-stream reset keeps the word
    always_ff @(posedge clk) begin
        if (load_in) begin
            hold_q  <= word_in;
            shown_q <= hold_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load_in)
            ptr_q <= '0;
        else if ({1'b0, ptr_q} >= ratio - 4'd1)
            ptr_q <= '0;
        else
            ptr_q <= ptr_q + 1'b1;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_wide
        assign wide_lane[g] = shown_q[g*CW +: CW];
    end

    for (genvar g = 0; g < MAX_RATIO; g++) begin : g_narrow
        assign narrow_lane[g] = shown_q[g*PW +: PW];
    end

    assign pix_out = pseudo ? CW'(narrow_lane[ptr_q]) : wide_lane[ptr_q[WSEL-1:0]];

    // R5: a latch always restarts the playout at lane A
    p_latch_lane_a_r5: assert property (@(posedge clk) disable iff (rst)
        load_in |=> (ptr_q == '0));

    // R8: reset returns the lane index to A
    p_reset_lane_a_r8: assert property (@(posedge clk)
        rst |=> (ptr_q == '0));

endmodule

// File: rtl/pxser_top.sv
module pxser_top
    import pxser_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CW    = 24,
    parameter int PW    = 8
)(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_mux,
    input  logic [1:0]          cfg_pdiv,
    input  logic                load_in,
    input  logic [LANES*CW-1:0] pix_word,
    output logic                load_out,
    output logic                prg_clk,
    output logic [CW-1:0]       pix_out,
    output logic                pseudo_mode
);
    cfg_t       cfg_q;
    logic [3:0] ratio;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_DEFAULT;
        else if (cfg_we)
            cfg_q <= '{mux: mux_e'(cfg_mux), pdiv: pdiv_e'(cfg_pdiv)};
    end

    assign ratio       = mux_ratio(cfg_q.mux);
    assign pseudo_mode = mux_is_pseudo(cfg_q.mux);

    pxser_load_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .ratio    (ratio),
        .load_out (load_out)
    );

    pxser_prog_div u_pdiv (
        .clk     (clk),
        .rst     (rst),
        .pdiv    (cfg_q.pdiv),
        .prg_clk (prg_clk)
    );

    pxser_lane_mux #(.LANES(LANES), .CW(CW), .PW(PW)) u_lanes (
        .clk     (clk),
        .rst     (rst),
        .load_in (load_in),
        .word_in (pix_word),
        .ratio   (ratio),
        .pseudo  (pseudo_mode),
        .pix_out (pix_out)
    );

    // R4: in eight-per-load mode the upper pixel bits stay zero
    p_pseudo_narrow_r4: assert property (@(posedge clk) disable iff (rst)
        pseudo_mode |-> (pix_out[CW-1:PW] == '0));

    // R1: defaults are in force right after reset
    p_reset_cfg_r1: assert property (@(posedge clk)
        rst |=> (!pseudo_mode && !prg_clk && load_out));

endmodule

// File: tb/pxser_top_tb_top.sv
module pxser_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_mux = 2'd0;
    logic [1:0]  cfg_pdiv = 2'd0;
    logic        load_in = 1'b0;
    logic [95:0] pix_word = '0;
    logic        load_out, prg_clk, pseudo_mode;
    logic [23:0] pix_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // behavioural reference state
    int          m_mux, m_pdiv, m_ph, m_pc, m_ptr, m_loads;
    bit          m_skip;
    logic [95:0] m_hold, m_shown;
    logic        prev_load_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pxser_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mux(cfg_mux),
        .cfg_pdiv(cfg_pdiv), .load_in(load_in), .pix_word(pix_word),
        .load_out(load_out), .prg_clk(prg_clk), .pix_out(pix_out),
        .pseudo_mode(pseudo_mode)
    );

    function automatic int ratio_of(int m);
        return (m == 0) ? 2 : (m == 1) ? 4 : 8;
    endfunction

    task automatic check(bit ok, string tag, logic [95:0] act, logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int n = ratio_of(m_mux);
        m_skip = 0;
        if (load_in) begin
            m_shown = m_hold;
            m_hold  = pix_word;
            m_loads++;
        end
        if (rst) begin
            m_mux = 1; m_pdiv = 3; m_ph = 0; m_pc = 0; m_ptr = 0;
        end else begin
            m_ph  = (m_ph >= n-1) ? 0 : m_ph + 1;
            m_pc  = (m_pc + 1) % 32;
            m_ptr = load_in ? 0 : ((m_ptr >= n-1) ? 0 : m_ptr + 1);
            if (cfg_we) begin
                m_mux = int'(cfg_mux); m_pdiv = int'(cfg_pdiv); m_skip = 1;
            end
        end
    endtask

    function automatic logic [23:0] exp_pix();
        if (m_mux >= 2) return {16'h0, m_shown[m_ptr*8 +: 8]};
        return m_shown[m_ptr*24 +: 24];
    endfunction

    task automatic compare_all();
        logic exp_prg = 1'(m_pc >> (m_pdiv + 1));
        logic exp_ps  = (m_mux >= 2);
        check(load_out === (m_ph == 0), "R2 load_out", 96'(load_out), 96'(m_ph == 0));
        check(prg_clk === exp_prg, "R3 prg_clk", 96'(prg_clk), 96'(exp_prg));
        check(pseudo_mode === exp_ps, "R7 pseudo_mode", 96'(pseudo_mode), 96'(exp_ps));
        if (m_loads >= 2 && !m_skip) begin
            if (exp_ps)
                check(pix_out === exp_pix(), "R4 narrow pixel", 96'(pix_out), 96'(exp_pix()));
            else if (m_ptr == 0)
                check(pix_out === exp_pix(), "R5 lane A after latch", 96'(pix_out), 96'(exp_pix()));
            else
                check(pix_out === exp_pix(), "R6 lane order", 96'(pix_out), 96'(exp_pix()));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    // mode 0: direct loopback, 1: one-cycle delayed loopback, 2: no latch
    task automatic run(int mux, int pdiv, int cycles, int mode);
        cfg_we = 1; cfg_mux = 2'(mux); cfg_pdiv = 2'(pdiv);
        load_in = (mode == 0) ? load_out : (mode == 1) ? prev_load_out : 1'b0;
        pix_word = {$urandom, $urandom, $urandom};
        prev_load_out = load_out;
        tick();
        cfg_we = 0;
        for (int i = 0; i < cycles; i++) begin
            load_in = (mode == 0) ? load_out : (mode == 1) ? prev_load_out : 1'b0;
            pix_word = {$urandom, $urandom, $urandom};
            prev_load_out = load_out;
            tick();
        end
    endtask

    initial begin
        m_loads = 0; m_skip = 0; m_hold = '0; m_shown = '0;
        m_mux = 1; m_pdiv = 3; m_ph = 0; m_pc = 0; m_ptr = 0;
        rst = 1;
        repeat (3) tick();
        // R1: defaults after reset
        check(load_out === 1'b1, "R1 load_out", 96'(load_out), 96'(1));
        check(prg_clk === 1'b0, "R1 prg_clk", 96'(prg_clk), 96'(0));
        check(pseudo_mode === 1'b0, "R1 pseudo_mode", 96'(pseudo_mode), 96'(0));
        rst = 0;
        for (int i = 0; i < 70; i++) begin
            load_in = load_out;
            pix_word = {$urandom, $urandom, $urandom};
            prev_load_out = load_out;
            tick();
        end
        run(0, 0, 60, 0);
        run(2, 1, 80, 1);
        run(1, 2, 60, 1);
        run(3, 3, 70, 0);
        run(1, 0, 40, 0);
        // R8: reset while a word is playing out
        while (m_ptr != 2) begin
            load_in = 0; tick();
        end
        load_in = 0; rst = 1;
        tick();
        rst = 0;
        check(pix_out === m_shown[23:0], "R8 lane A after reset",
              96'(pix_out), 96'(m_shown[23:0]));
        run(0, 1, 30, 2);
        run(2, 2, 40, 2);
        run(1, 3, 60, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule